// File: doc/BRIEF.md
# Receive Queue with Head-Aligned Error Status

This block sits behind a serial receiver's deserializer. Each finished character arrives as one byte plus two error tags, one for parity and one for framing. The block keeps these characters in a four-entry first-in first-out queue. Software sees the oldest byte on a read port and learns the state of the channel from an eight-bit status word.

Error reporting follows the queue. A tag stored with a character shows up in status only when that character becomes the oldest entry. An overflow is recorded against the newest character that was stored before it happened. While that mark is pending, the queue accepts nothing, so the first character that software reads after the error flag appears is the last good one. Status also holds two interrupt enables, a transmit-empty flag passed in from the transmitter, and the carrier-detect level.

Top module: `rx_err_fifo`

## Requirements
- R1: Status bit 7 (data ready) becomes 1 in the cycle after a character enters an empty queue. It stays 1 while any entry remains and returns to 0 when the last entry is popped.
- R2: The queue keeps DEPTH (4) entries in arrival order. `rd_data` always shows the oldest entry, and a `rd_pop` pulse removes it. A pop on an empty queue has no effect.
- R3: A character that arrives while DEPTH entries are stored and no pop happens in the same cycle is an overrun and is discarded. Status bit 6 stays 0 until the newest character stored before the overrun is the oldest entry, and becomes 1 from then on.
- R4: After an overrun, every arriving character is discarded until the marked entry has spent a cycle at the head, even when pops free slots in the meantime. The first character after that is stored.
- R5: A character that carries a parity or framing tag is stored like any other character and sets status bit 7.
- R6: Status bit 5 (parity) and bit 4 (framing) become 1 only when a tagged character is the oldest entry. They then stay 1 after that character is popped.
- R7: Status bits 6, 5 and 4 read 0, and their latched state is cleared, in each of three cases:
  - in a cycle where `err_clr` is 1;
  - while `io_stop` is 1;
  - while `cd_auto` and `cd_n` are both 1.
  
  `cd_n` = 1 with `cd_auto` = 0 clears nothing.
- R8: A cycle with `cfg_wr` = 1 loads `cfg_rie` into status bit 3 and `cfg_tie` into status bit 0. Status bit 2 shows `cd_n` and bit 1 shows `tx_empty`. After reset the status word is {4'b0000, 1'b0, cd_n, tx_empty, 1'b0}.
- R9: `rx_irq` is 1 exactly when status bit 3 is 1 and at least one of status bits 7, 6, 5 or 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | 8 | Received byte |
| char_perr | input | 1 | Parity error tag for the byte |
| char_ferr | input | 1 | Framing error tag for the byte |
| rd_pop | input | 1 | Read of the data port; removes the oldest entry |
| rd_data | output | 8 | Oldest stored byte |
| err_clr | input | 1 | Error-flag reset strobe |
| io_stop | input | 1 | Stop mode level; holds the error flags cleared |
| cd_auto | input | 1 | Carrier-detect automatic handling enabled |
| cd_n | input | 1 | Carrier-detect input, active low |
| tx_empty | input | 1 | Transmit data register empty, from the transmitter |
| cfg_wr | input | 1 | Write strobe for the two interrupt enables |
| cfg_rie | input | 1 | Receive interrupt enable value to load |
| cfg_tie | input | 1 | Transmit interrupt enable value to load |
| status | output | 8 | {ready, overrun, parity, framing, rie, cd_n, tx_empty, tie} |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach from the ports is a frozen queue that already has free slots while the overrun flag is still hidden. The stimulus fills all four entries and sends a fifth character to cause the overrun. It then pops one entry and sends another character, which must also be discarded. After two more pops the marked character reaches the head, and only then does the overrun bit appear. The bench waits one idle cycle and checks that the next character is accepted, and that it is read out right after the marked one.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_valid,
  input  logic [DW-1:0] char_data,
  input  logic          char_perr,
  input  logic          char_ferr,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  input  logic          err_clr,
  input  logic          io_stop,
  input  logic          cd_auto,
  input  logic          cd_n,
  input  logic          tx_empty,
  input  logic          cfg_wr,
  input  logic          cfg_rie,
  input  logic          cfg_tie,
  output logic [7:0]    status,
  output logic          rx_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [DW-1:0]    q_d [DEPTH];
  logic [DEPTH-1:0] q_pe, q_fe, q_ov;
  logic [AW-1:0]    rd_ptr, wr_ptr, newest;
  logic [AW:0]      cnt;
  logic             frozen, ovr_st, pe_st, fe_st, rie, tie;

  wire nonempty = (cnt != '0);
  wire full     = (cnt == FULL);
  wire do_pop   = rd_pop & nonempty;
  wire accept   = char_valid & ~frozen & (~full | do_pop);
  wire ovf      = char_valid & ~frozen & full & ~do_pop;
  wire clr_now  = err_clr | io_stop | (cd_auto & cd_n);
  wire head_ov  = nonempty & q_ov[rd_ptr];
  wire head_pe  = nonempty & q_pe[rd_ptr];
  wire head_fe  = nonempty & q_fe[rd_ptr];

  assign newest  = wr_ptr - 1'b1;
  assign rd_data = q_d[rd_ptr];

  wire ovr_vis = ~clr_now & (ovr_st | head_ov);
  wire pe_vis  = ~clr_now & (pe_st | head_pe);
  wire fe_vis  = ~clr_now & (fe_st | head_fe);

  assign status = {nonempty, ovr_vis, pe_vis, fe_vis, rie, cd_n, tx_empty, tie};
  assign rx_irq = rie & (nonempty | ovr_vis | pe_vis | fe_vis);

  always_ff @(posedge clk) begin
    if (accept) q_d[wr_ptr] <= char_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, accept} - {{AW{1'b0}}, do_pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_pe <= '0;
      q_fe <= '0;
      q_ov <= '0;
    end else begin
      if (nonempty) begin
        q_pe[rd_ptr] <= 1'b0;
        q_fe[rd_ptr] <= 1'b0;
        q_ov[rd_ptr] <= 1'b0;
      end
      if (accept) begin
        q_pe[wr_ptr] <= char_perr;
        q_fe[wr_ptr] <= char_ferr;
        q_ov[wr_ptr] <= 1'b0;
      end
      if (ovf) q_ov[newest] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frozen <= 1'b0;
    else if (ovf) frozen <= 1'b1;
    else if (frozen & head_ov) frozen <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_st <= 1'b0;
      pe_st  <= 1'b0;
      fe_st  <= 1'b0;
    end else if (clr_now) begin
      ovr_st <= 1'b0;
      pe_st  <= 1'b0;
      fe_st  <= 1'b0;
    end else begin
      ovr_st <= ovr_st | head_ov;
      pe_st  <= pe_st | head_pe;
      fe_st  <= fe_st | head_fe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rie <= 1'b0;
      tie <= 1'b0;
    end else if (cfg_wr) begin
      rie <= cfg_rie;
      tie <= cfg_tie;
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);
  a_r1_ready_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!nonempty && accept) |=> status[7]);
  a_r4_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !do_pop) |=> $stable(cnt));
  a_r3_ovr_latched_at_head: assert property (@(posedge clk) disable iff (!rst_n)
    (head_ov && !clr_now) |=> ovr_st);
  a_r7_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (!ovr_st && !pe_st && !fe_st));
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> status[3]);
endmodule

// File: tb/rx_err_fifo_tb.sv
module rx_err_fifo_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic char_valid = 0, char_perr = 0, char_ferr = 0, rd_pop = 0;
  logic [7:0] char_data = 0;
  logic err_clr = 0, io_stop = 0, cd_auto = 0, cd_n = 0, tx_empty = 1;
  logic cfg_wr = 0, cfg_rie = 0, cfg_tie = 0;
  logic [7:0] rd_data, status;
  logic rx_irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  rx_err_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .rd_pop(rd_pop), .rd_data(rd_data),
    .err_clr(err_clr), .io_stop(io_stop), .cd_auto(cd_auto), .cd_n(cd_n),
    .tx_empty(tx_empty), .cfg_wr(cfg_wr), .cfg_rie(cfg_rie), .cfg_tie(cfg_tie),
    .status(status), .rx_irq(rx_irq));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk);
    char_valid = 1; char_data = d; char_perr = pe; char_ferr = fe;
    @(negedge clk);
    char_valid = 0; char_perr = 0; char_ferr = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd_pop = 1;
    @(negedge clk); rd_pop = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic t_reset();
    check("R8 reset status", status, 8'h02);
    check("R1 reset rx_irq", {7'b0, rx_irq}, 8'h00);
  endtask

  task automatic t_order();
    send(8'h11, 0, 0);
    check("R1 ready after first", {7'b0, status[7]}, 8'h01);
    send(8'h22, 0, 0);
    send(8'h33, 0, 0);
    check("R2 head data", rd_data, 8'h11);
    pop(); check("R2 second", rd_data, 8'h22);
    pop(); check("R1 ready while entries", {7'b0, status[7]}, 8'h01);
    check("R2 third", rd_data, 8'h33);
    pop(); check("R1 ready cleared", {7'b0, status[7]}, 8'h00);
    pop(); check("R2 pop empty ignored", {7'b0, status[7]}, 8'h00);
    send(8'h44, 0, 0);
    check("R2 after empty pop", rd_data, 8'h44);
    pop();
  endtask

  task automatic t_overrun();
    send(8'hA1, 0, 0); send(8'hA2, 0, 0); send(8'hA3, 0, 0); send(8'hA4, 0, 0);
    send(8'hE5, 0, 0);
    check("R3 ovr hidden", {7'b0, status[6]}, 8'h00);
    pop();
    send(8'hF6, 0, 0);
    check("R3 ovr still hidden", {7'b0, status[6]}, 8'h00);
    pop();
    check("R2 head A3", rd_data, 8'hA3);
    check("R3 ovr hidden at A3", {7'b0, status[6]}, 8'h00);
    pop();
    check("R3 head A4", rd_data, 8'hA4);
    check("R3 ovr visible at marked head", {7'b0, status[6]}, 8'h01);
    @(negedge clk);
    send(8'hC7, 0, 0);
    pop();
    check("R4 next after marked", rd_data, 8'hC7);
    check("R3 ovr sticky", {7'b0, status[6]}, 8'h01);
    pop();
    check("R4 queue empty", {7'b0, status[7]}, 8'h00);
    pulse_clr();
    check("R7 err_clr clears ovr", {7'b0, status[6]}, 8'h00);
  endtask

  task automatic t_parity();
    send(8'h51, 0, 0);
    send(8'h52, 1, 0);
    check("R5 tagged stored", rd_data, 8'h51);
    check("R6 pe hidden", {7'b0, status[5]}, 8'h00);
    pop();
    check("R5 tagged head", rd_data, 8'h52);
    check("R6 pe at head", {7'b0, status[5]}, 8'h01);
    pop();
    check("R6 pe sticky", {7'b0, status[5]}, 8'h01);
    pulse_clr();
    check("R7 pe cleared", {7'b0, status[5]}, 8'h00);
  endtask

  task automatic t_framing();
    send(8'h61, 0, 1);
    check("R5 ready for tagged", {7'b0, status[7]}, 8'h01);
    check("R6 fe at head", {7'b0, status[4]}, 8'h01);
    @(negedge clk); io_stop = 1;
    @(negedge clk);
    check("R7 io_stop clears fe", {7'b0, status[4]}, 8'h00);
    io_stop = 0;
    @(negedge clk);
    check("R7 fe stays cleared", {7'b0, status[4]}, 8'h00);
    pop();
    send(8'h62, 0, 1);
    cd_n = 1;
    @(negedge clk);
    check("R7 cd_n without auto", {7'b0, status[4]}, 8'h01);
    check("R8 cd level shown", {7'b0, status[2]}, 8'h01);
    cd_auto = 1;
    @(negedge clk);
    check("R7 cd auto clears fe", {7'b0, status[4]}, 8'h00);
    cd_auto = 0; cd_n = 0;
    pop();
  endtask

  task automatic t_irq();
    tx_empty = 0;
    @(negedge clk);
    check("R8 tx_empty shown", status, 8'h00);
    @(negedge clk); cfg_wr = 1; cfg_rie = 1; cfg_tie = 1;
    @(negedge clk); cfg_wr = 0; cfg_rie = 0; cfg_tie = 0;
    check("R8 enables readback", status, 8'h09);
    check("R9 no irq empty", {7'b0, rx_irq}, 8'h00);
    send(8'h71, 0, 0);
    check("R9 irq on data", {7'b0, rx_irq}, 8'h01);
    @(negedge clk); cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
    check("R9 irq masked", {7'b0, rx_irq}, 8'h00);
    pop();
    tx_empty = 1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_order();
        t_overrun();
        t_parity();
        t_framing();
        t_irq();
      end
      begin
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired got=0 exp=1");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule